// File: doc/BRIEF.md
# Address-Range Access Guard

This block vets every memory access a processor core is about to make: data loads, data stores and instruction fetches. Each access arrives with its 32-bit address, its kind and the core's current privilege mode. When protection is switched on, the block grants the access only if the address lies inside a range of the active register set and that range allows that kind of access. Otherwise it reports a violation and a cause code, so that the surrounding logic can suppress the access and raise the right trap.

The block holds several identical register sets. Each set has a parameterised number of data ranges, which cover loads and stores, and code ranges, which cover fetches. A range has an inclusive lower bound, an exclusive upper bound and three enable bits. A small selector register names the active set. An operating system can therefore prepare one protection map per task and switch maps on a task switch with a single selector write. Range registers and the selector can be written only while the core runs in supervisor mode.

Top module: `mpc_guard`

## Requirements
- R1: While `prot_on` is 0, every access presented on `acc_valid` is granted.
- R2: While `prot_on` is 1, a read (`acc_kind` 00) is granted only if its address lies in a data range of the active set whose read bit is set, and a write (`acc_kind` 01) only if it lies in a data range whose write bit is set. Permission bits are written as `cfg_wdata[0]`=read, `[1]`=write, `[2]`=execute.
- R3: A fetch (`acc_kind` 1x) is checked only against code ranges (slots `DATA_RANGES` and above) using their execute bit. Data ranges (slots 0 to `DATA_RANGES-1`) never grant a fetch, and code ranges never grant a read or a write.
- R4: A range covers the addresses a with lower <= a < upper. A range whose lower bound is not below its upper bound covers nothing.
- R5: The active set is the one named by `active_set`. A supervisor write on `sel_we` with a value below `NUM_SETS` makes that set active from the next cycle, and the protection map changes with no range rewrite.
- R6: Range writes (`cfg_we`) and selector writes (`sel_we`) take effect only when `priv_mode` is 10 (supervisor). In user-0 (00) and user-1 (01) modes they change nothing.
- R7: The verdict appears on `res_valid`/`grant`/`violation` one cycle after `acc_valid`. Exactly one of `grant` and `violation` is high with `res_valid`, and all three are low after a cycle without a request.
- R8: `viol_cause` is 01 for a denied read, 10 for a denied write, 11 for a denied fetch, and 00 whenever no violation is reported.
- R9: Reset clears all ranges to empty with no permissions, selects set 0 and drives all outputs low.
- R10: A range write takes effect for accesses presented after the clock edge that stores it. An access presented in the same cycle as the write is judged against the old contents.
- R11: Range writes address a bank by `cfg_set` and a slot by `cfg_slot`. `cfg_field` 00 writes the lower bound, 01 the upper bound and 10 the permission bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 00 read, 01 write, 1x fetch |
| priv_mode | input | 2 | 00 user-0, 01 user-1, 10 supervisor |
| prot_on | input | 1 | Protection enable |
| cfg_we | input | 1 | Range register write strobe |
| cfg_set | input | SET_W | Bank being written |
| cfg_slot | input | SLOT_W | Range slot being written |
| cfg_field | input | 2 | 00 lower, 01 upper, 10 permissions |
| cfg_wdata | input | 32 | Write data |
| sel_we | input | 1 | Active-set selector write strobe |
| sel_wdata | input | SET_W | New active set |
| active_set | output | SET_W | Currently active set |
| res_valid | output | 1 | Verdict valid |
| grant | output | 1 | Access allowed |
| violation | output | 1 | Access denied |
| viol_cause | output | 2 | Kind of the denied access |

## Verification
The bench builds the guard with its defaults: four sets, four data ranges and two code ranges per set. At these sizes it can place neighbouring ranges that share a bound, so the inclusive and exclusive edges show up on adjacent addresses. Data and code slots can cover the same addresses, which shows that each access kind looks only at its own slot class. Two sets hold different permissions for one address, so a selector write alone is seen to change the verdict. A range write issued in the same cycle as an access to that range brings the write-ordering rule within reach.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  localparam int PROT_AW = 32;

  localparam logic [1:0] PRIV_USER0 = 2'b00;
  localparam logic [1:0] PRIV_USER1 = 2'b01;
  localparam logic [1:0] PRIV_SUPER = 2'b10;

  localparam logic [1:0] CAUSE_NONE  = 2'b00;
  localparam logic [1:0] CAUSE_READ  = 2'b01;
  localparam logic [1:0] CAUSE_WRITE = 2'b10;
  localparam logic [1:0] CAUSE_FETCH = 2'b11;

  localparam logic [1:0] FLD_LOWER = 2'b00;
  localparam logic [1:0] FLD_UPPER = 2'b01;
  localparam logic [1:0] FLD_PERM  = 2'b10;

  typedef struct packed {
    logic [PROT_AW-1:0] lower;
    logic [PROT_AW-1:0] upper;
    logic               may_fetch;
    logic               may_write;
    logic               may_read;
  } prot_range_t;

  // Lower bound inclusive, upper bound exclusive; lower >= upper covers nothing.
  function automatic logic addr_inside(logic [PROT_AW-1:0] a, prot_range_t r);
    return (a >= r.lower) && (a < r.upper);
  endfunction

  function automatic logic kind_is_fetch(logic [1:0] k);
    return k[1];
  endfunction

  function automatic logic perm_for_kind(prot_range_t r, logic [1:0] k);
    if (k[1]) return r.may_fetch;
    else if (k[0]) return r.may_write;
    else return r.may_read;
  endfunction

  function automatic logic [1:0] cause_of(logic [1:0] k);
    if (k[1]) return CAUSE_FETCH;
    else if (k[0]) return CAUSE_WRITE;
    else return CAUSE_READ;
  endfunction

endpackage

// File: rtl/mpc_set_bank.sv
module mpc_set_bank
  import mpc_pkg::*;
#(
  parameter int TOTAL_RANGES = 6,
  parameter int SLOT_W       = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic [1:0]          wr_field,
  input  logic [PROT_AW-1:0]  wr_data,
  output prot_range_t         ranges_o [TOTAL_RANGES]
);

  for (genvar g = 0; g < TOTAL_RANGES; g++) begin : g_slot
    prot_range_t slot_q;
    logic        slot_hit;

    assign slot_hit    = wr_en && (wr_slot == SLOT_W'(g));
    assign ranges_o[g] = slot_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_hit) begin
        case (wr_field)
          FLD_LOWER: slot_q.lower <= wr_data;
          FLD_UPPER: slot_q.upper <= wr_data;
          FLD_PERM: begin
            slot_q.may_read  <= wr_data[0];
            slot_q.may_write <= wr_data[1];
            slot_q.may_fetch <= wr_data[2];
          end
          default: slot_q <= slot_q;
        endcase
      end
    end
  end

endmodule

// File: rtl/mpc_range_match.sv
module mpc_range_match
  import mpc_pkg::*;
#(
  parameter bit IS_CODE = 1'b0
) (
  input  logic [PROT_AW-1:0] addr,
  input  logic [1:0]         kind,
  input  prot_range_t        rng,
  output logic               hit,
  output logic               allow
);

  logic class_ok;

  assign class_ok = (kind_is_fetch(kind) == IS_CODE);
  assign hit      = class_ok && addr_inside(addr, rng);
  assign allow    = hit && perm_for_kind(rng, kind);

endmodule

// File: rtl/mpc_verdict.sv
module mpc_verdict
  import mpc_pkg::*;
#(
  parameter int TOTAL_RANGES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic [1:0]              acc_kind,
  input  logic                    prot_on,
  input  logic [TOTAL_RANGES-1:0] allow_vec,
  output logic                    any_allow,
  output logic                    pass_now,
  output logic                    res_valid,
  output logic                    grant,
  output logic                    violation,
  output logic [1:0]              viol_cause
);

  assign any_allow = |allow_vec;
  assign pass_now  = !prot_on || any_allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      grant      <= 1'b0;
      violation  <= 1'b0;
      viol_cause <= CAUSE_NONE;
    end else begin
      res_valid  <= acc_valid;
      grant      <= acc_valid && pass_now;
      violation  <= acc_valid && !pass_now;
      viol_cause <= (acc_valid && !pass_now) ? cause_of(acc_kind) : CAUSE_NONE;
    end
  end

endmodule

// File: rtl/mpc_guard.sv
module mpc_guard
  import mpc_pkg::*;
#(
  parameter int NUM_SETS    = 4,
  parameter int DATA_RANGES = 4,
  parameter int CODE_RANGES = 2,
  localparam int TOTAL_RANGES = DATA_RANGES + CODE_RANGES,
  localparam int SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int SLOT_W = (TOTAL_RANGES > 1) ? $clog2(TOTAL_RANGES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [PROT_AW-1:0] acc_addr,
  input  logic [1:0]         acc_kind,
  input  logic [1:0]         priv_mode,
  input  logic               prot_on,
  input  logic               cfg_we,
  input  logic [SET_W-1:0]   cfg_set,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic [1:0]         cfg_field,
  input  logic [PROT_AW-1:0] cfg_wdata,
  input  logic               sel_we,
  input  logic [SET_W-1:0]   sel_wdata,
  output logic [SET_W-1:0]   active_set,
  output logic               res_valid,
  output logic               grant,
  output logic               violation,
  output logic [1:0]         viol_cause
);

  // Named internal events, observed by the bound checker.
  logic                    is_super;
  logic                    cfg_accept;
  logic                    sel_accept;
  logic [TOTAL_RANGES-1:0] hit_vec;
  logic [TOTAL_RANGES-1:0] allow_vec;
  logic                    any_allow;
  logic                    pass_now;

  logic [SET_W-1:0] sel_q;
  prot_range_t      bank_ranges  [NUM_SETS][TOTAL_RANGES];
  prot_range_t      active_ranges [TOTAL_RANGES];

  assign is_super   = (priv_mode == PRIV_SUPER);
  assign cfg_accept = cfg_we && is_super && (int'(cfg_set) < NUM_SETS);
  assign sel_accept = sel_we && is_super && (int'(sel_wdata) < NUM_SETS);

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (sel_accept) sel_q <= sel_wdata;
  end
  assign active_set = sel_q;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_bank
    logic bank_we;
    assign bank_we = cfg_accept && (cfg_set == SET_W'(s));

    mpc_set_bank #(
      .TOTAL_RANGES (TOTAL_RANGES),
      .SLOT_W       (SLOT_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_we),
      .wr_slot  (cfg_slot),
      .wr_field (cfg_field),
      .wr_data  (cfg_wdata),
      .ranges_o (bank_ranges[s])
    );
  end

  always_comb begin
    for (int r = 0; r < TOTAL_RANGES; r++) active_ranges[r] = bank_ranges[0][r];
    for (int s = 1; s < NUM_SETS; s++) begin
      if (sel_q == SET_W'(s)) begin
        for (int r = 0; r < TOTAL_RANGES; r++) active_ranges[r] = bank_ranges[s][r];
      end
    end
  end

  for (genvar g = 0; g < TOTAL_RANGES; g++) begin : g_match
    mpc_range_match #(
      .IS_CODE (g >= DATA_RANGES)
    ) u_match (
      .addr  (acc_addr),
      .kind  (acc_kind),
      .rng   (active_ranges[g]),
      .hit   (hit_vec[g]),
      .allow (allow_vec[g])
    );
  end

  mpc_verdict #(
    .TOTAL_RANGES (TOTAL_RANGES)
  ) u_verdict (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_kind   (acc_kind),
    .prot_on    (prot_on),
    .allow_vec  (allow_vec),
    .any_allow  (any_allow),
    .pass_now   (pass_now),
    .res_valid  (res_valid),
    .grant      (grant),
    .violation  (violation),
    .viol_cause (viol_cause)
  );

endmodule

// File: rtl/mpc_guard_chk.sv
module mpc_guard_chk #(
  parameter int NUM_SETS = 4,
  parameter int SET_W    = 2,
  parameter int TOTAL    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [1:0]       acc_kind,
  input logic [1:0]       priv_mode,
  input logic             prot_on,
  input logic             sel_we,
  input logic [SET_W-1:0] sel_wdata,
  input logic [SET_W-1:0] active_set,
  input logic [TOTAL-1:0] hit_vec,
  input logic             any_allow,
  input logic             res_valid,
  input logic             grant,
  input logic             violation,
  input logic [1:0]       viol_cause
);

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && violation));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (res_valid && (grant || violation)));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!res_valid && !grant && !violation));

  assert_open_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !prot_on) |=> grant);

  assert_deny_without_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && prot_on && !any_allow) |=> violation);

  assert_no_match_no_allow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |-> !any_allow);

  assert_user_sel_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && priv_mode != 2'b10) |=> $stable(active_set));

  assert_super_sel_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && priv_mode == 2'b10 && int'(sel_wdata) < NUM_SETS)
      |=> (active_set == $past(sel_wdata)));

  assert_set_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(active_set) < NUM_SETS);

  assert_cause_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    violation == (viol_cause != 2'b00));

  assert_write_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'b01) |=> (!violation || viol_cause == 2'b10));

  assert_fetch_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind[1]) |=> (!violation || viol_cause == 2'b11));

endmodule

bind mpc_guard mpc_guard_chk #(
  .NUM_SETS (NUM_SETS),
  .SET_W    (SET_W),
  .TOTAL    (TOTAL_RANGES)
) u_guard_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_kind   (acc_kind),
  .priv_mode  (priv_mode),
  .prot_on    (prot_on),
  .sel_we     (sel_we),
  .sel_wdata  (sel_wdata),
  .active_set (active_set),
  .hit_vec    (hit_vec),
  .any_allow  (any_allow),
  .res_valid  (res_valid),
  .grant      (grant),
  .violation  (violation),
  .viol_cause (viol_cause)
);

// File: tb/tb_mpc_guard.sv
module tb_mpc_guard;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_kind;
  logic [1:0]  priv_mode;
  logic        prot_on;
  logic        cfg_we;
  logic [1:0]  cfg_set;
  logic [2:0]  cfg_slot;
  logic [1:0]  cfg_field;
  logic [31:0] cfg_wdata;
  logic        sel_we;
  logic [1:0]  sel_wdata;
  logic [1:0]  active_set;
  logic        res_valid, grant, violation;
  logic [1:0]  viol_cause;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mpc_guard dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .priv_mode(priv_mode), .prot_on(prot_on),
    .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_slot(cfg_slot),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .sel_we(sel_we),
    .sel_wdata(sel_wdata), .active_set(active_set), .res_valid(res_valid),
    .grant(grant), .violation(violation), .viol_cause(viol_cause)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  kind;
    logic        ok;
  } vec_t;

  // Set 0 map: slot0 [1000,2000) R, slot1 [2000,3000) RW,
  // slot2 [9000,A000) X only (data slot), slot4 [8000,9000) X (code slot).
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_1000, 2'b00, 1'b1},  // R4 inclusive lower bound
    '{32'h0000_0FFF, 2'b00, 1'b0},  // R4 below range
    '{32'h0000_1FFF, 2'b01, 1'b0},  // R2 read-only range refuses write
    '{32'h0000_2000, 2'b01, 1'b1},  // R4 upper of slot0 excluded, slot1 RW
    '{32'h0000_2FFF, 2'b00, 1'b1},  // R2 read in RW range
    '{32'h0000_3000, 2'b00, 1'b0},  // R4 exclusive upper bound
    '{32'h0000_8000, 2'b10, 1'b1},  // R3 fetch from code range
    '{32'h0000_8FFF, 2'b00, 1'b0},  // R3 code range never grants read
    '{32'h0000_8FFF, 2'b01, 1'b0},  // R3 code range never grants write
    '{32'h0000_9000, 2'b10, 1'b0},  // R3 data range never grants fetch
    '{32'h0000_9000, 2'b00, 1'b0},  // R2 no read bit
    '{32'h0000_8004, 2'b11, 1'b1}   // R3 kind 11 is a fetch
  };

  function automatic logic [1:0] exp_cause(logic [1:0] k, logic ok);
    if (ok) return 2'b00;
    if (k[1]) return 2'b11;
    if (k[0]) return 2'b10;
    return 2'b01;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] s, logic [2:0] slot, logic [1:0] f,
                           logic [31:0] d, logic [1:0] pm);
    @(negedge clk);
    priv_mode = pm; cfg_we = 1'b1; cfg_set = s; cfg_slot = slot;
    cfg_field = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; priv_mode = 2'b10;
  endtask

  task automatic set_range(logic [1:0] s, logic [2:0] slot, logic [31:0] lo,
                           logic [31:0] hi, logic [2:0] perm);
    cfg_write(s, slot, 2'b00, lo, 2'b10);
    cfg_write(s, slot, 2'b01, hi, 2'b10);
    cfg_write(s, slot, 2'b10, {29'd0, perm}, 2'b10);
  endtask

  task automatic sel_write(logic [1:0] v, logic [1:0] pm);
    @(negedge clk);
    priv_mode = pm; sel_we = 1'b1; sel_wdata = v;
    @(negedge clk);
    sel_we = 1'b0; priv_mode = 2'b10;
  endtask

  // Drive at a falling edge, the verdict registers at the next rising edge,
  // sample at the following falling edge.
  task automatic access(string tag, logic [31:0] a, logic [1:0] k, logic ok);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_kind = k;
    @(negedge clk);
    acc_valid = 1'b0;
    check({tag, " res_valid"}, 32'(res_valid), 32'd1);
    check({tag, " grant"}, 32'(grant), 32'(ok));
    check({tag, " violation"}, 32'(violation), 32'(!ok));
    check({tag, " R8 cause"}, 32'(viol_cause), 32'(exp_cause(k, ok)));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_kind = '0;
    priv_mode = 2'b10; prot_on = 1'b1; cfg_we = 1'b0; cfg_set = '0;
    cfg_slot = '0; cfg_field = '0; cfg_wdata = '0; sel_we = 1'b0; sel_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset res_valid", 32'(res_valid), 32'd0);
    check("R9 reset grant", 32'(grant), 32'd0);
    check("R9 reset violation", 32'(violation), 32'd0);
    check("R9 reset active_set", 32'(active_set), 32'd0);
    rst_n = 1'b1;

    // R9: empty ranges after reset deny everything
    access("R9 empty map read", 32'h0000_1000, 2'b00, 1'b0);
    access("R9 empty map fetch", 32'h0000_8000, 2'b10, 1'b0);
    // R1: protection off grants all
    prot_on = 1'b0;
    access("R1 off read", 32'hFFFF_0000, 2'b00, 1'b1);
    access("R1 off fetch", 32'h0000_0004, 2'b10, 1'b1);
    prot_on = 1'b1;
    // R7: idle cycle clears the verdict
    @(negedge clk);
    check("R7 idle res_valid", 32'(res_valid), 32'd0);
    check("R7 idle grant", 32'(grant), 32'd0);

    // R11: program set 0 and set 1
    set_range(2'd0, 3'd0, 32'h1000, 32'h2000, 3'b001);
    set_range(2'd0, 3'd1, 32'h2000, 32'h3000, 3'b011);
    set_range(2'd0, 3'd2, 32'h9000, 32'hA000, 3'b100);
    set_range(2'd0, 3'd4, 32'h8000, 32'h9000, 3'b100);
    set_range(2'd1, 3'd0, 32'h1000, 32'h2000, 3'b010);
    set_range(2'd1, 3'd5, 32'h1000, 32'h2000, 3'b100);

    for (int i = 0; i < NV; i++) begin
      access($sformatf("R2 vector %0d", i), VEC[i].addr, VEC[i].kind, VEC[i].ok);
    end

    // R6: selector write in user-1 mode is ignored
    sel_write(2'd1, 2'b01);
    check("R6 user sel active_set", 32'(active_set), 32'd0);
    access("R6 user sel map kept", 32'h0000_1000, 2'b00, 1'b1);

    // R5: supervisor selector write switches the map
    sel_write(2'd1, 2'b10);
    check("R5 sel active_set", 32'(active_set), 32'd1);
    access("R5 set1 read denied", 32'h0000_1000, 2'b00, 1'b0);
    access("R5 set1 write granted", 32'h0000_1000, 2'b01, 1'b1);
    access("R5 set1 fetch granted", 32'h0000_1800, 2'b10, 1'b1);

    // R6: range write in user-0 mode is ignored
    cfg_write(2'd1, 3'd0, 2'b10, 32'h1, 2'b00);
    access("R6 user cfg ignored", 32'h0000_1000, 2'b00, 1'b0);

    // R4: lower == upper covers nothing
    set_range(2'd1, 3'd3, 32'h5000, 32'h5000, 3'b001);
    access("R4 empty range", 32'h0000_5000, 2'b00, 1'b0);

    // R10: write and access in the same cycle; the access sees the old map
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = 2'd1; cfg_slot = 3'd3; cfg_field = 2'b01;
    cfg_wdata = 32'h6000; acc_valid = 1'b1; acc_addr = 32'h5000; acc_kind = 2'b00;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    check("R10 same-cycle grant", 32'(grant), 32'd0);
    check("R10 same-cycle violation", 32'(violation), 32'd1);
    access("R10 after write", 32'h0000_5000, 2'b00, 1'b1);
    access("R4 last inside", 32'h0000_5FFF, 2'b00, 1'b1);
    access("R4 upper excluded", 32'h0000_6000, 2'b00, 1'b0);

    // R5: back to set 0 restores the first map untouched
    sel_write(2'd0, 2'b10);
    access("R5 set0 restored", 32'h0000_1000, 2'b00, 1'b1);

    summary();
    $finish;
  end

endmodule